// File: doc/BRIEF.md
# Compressed Block Address Calculator

This block turns a cache-miss physical address into the location of the matching compressed block inside a compressed page. Each page holds 64 uncompressed blocks of 64 bytes. In the compressed layout every block takes one of four sizes, given by a 2-bit code. The codes for the whole page arrive together as one size vector. The page is split into two sub-pages of 32 blocks, and each sub-page starts at a base offset that the caller supplies. The block's compressed offset is that sub-page base plus the sum of the decoded sizes of the earlier blocks in the same sub-page. The block also returns the target's own compressed length. It raises a zero flag when the code marks the block as all-zero, so the load can finish without touching memory.

Requests and responses are both valid/ready streams, and a request is accepted only while `req_valid` and `req_ready` are both high at a rising edge. The output stage is a single register. `req_ready` is high when that register is empty, or when its content is being taken in the same cycle. A response that is not accepted stays unchanged until `rsp_ready` goes high. Back-to-back requests therefore run at one per cycle when the consumer never stalls.

Top module: `cblk_addr_calc`

## Requirements
- R1: Size code 2'b00 decodes to 0 bytes, 2'b01 to 16, 2'b10 to 32 and 2'b11 to 64. `rsp_len` is the decoded size of the target block's own code.
- R2: The target block index is `req_addr[11:6]`. Address bits [5:0] and bits above bit 11 have no effect on any response field.
- R3: `rsp_offset` equals the selected sub-page base plus the decoded sizes of every block that has a lower index in the same sub-page. Blocks 0..31 form sub-page 0 and blocks 32..63 form sub-page 1. Blocks in the other sub-page never contribute.
- R4: The first block of a sub-page (index 0 or 32) gets exactly that sub-page's base as its offset.
- R5: `rsp_zero` is 1 exactly when the target's code is 2'b00.
- R6: The response to a request accepted at one rising edge is presented with `rsp_valid` high right after that edge.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and every response field holds its value.
- R8: After reset `rsp_valid` is low and `req_ready` is high.
- R9: Block j's code sits at `req_size_vec[2j+1:2j]`. Sub-page s's base sits at `req_sub_base[13s+12:13s]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Cache-miss physical address |
| req_size_vec | input | 128 | Per-block 2-bit size codes of the page |
| req_sub_base | input | 26 | Byte base offset of each sub-page, 13 bits each |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_offset | output | 13 | Compressed byte offset of the target block |
| rsp_len | output | 7 | Compressed length of the target block in bytes |
| rsp_zero | output | 1 | Target block is all-zero |

## Verification
The corner cases are the first block of each sub-page, block 31 against block 32, and the last block 63. A design that gets the sub-page limit wrong either adds sub-page 0 sizes into a sub-page 1 offset or drops the base at block 32. An off-by-one in the range counts the target's own size in its offset, which shows up on every block whose code is not zero. Stalls are tested by holding `rsp_ready` low while a second request waits. A design that overwrites its output register, or that keeps `req_ready` high while stalled, delivers the second result and loses the first. Setting the address bits below and above the index field to noise exposes a wrong index slice.

// File: rtl/cblk_pkg.sv
package cblk_pkg;
  typedef enum logic [1:0] {
    SZC_ZERO    = 2'b00,
    SZC_QUARTER = 2'b01,
    SZC_HALF    = 2'b10,
    SZC_FULL    = 2'b11
  } size_code_e;
endpackage

// File: rtl/cblk_size_decode.sv
module cblk_size_decode #(
  parameter int BLK_BYTES = 64,
  parameter int LEN_W     = $clog2(BLK_BYTES + 1)
) (
  input  logic [1:0]       code,
  output logic [LEN_W-1:0] len
);
  import cblk_pkg::*;
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(BLK_BYTES);

  always_comb begin
    unique case (size_code_e'(code))
      SZC_ZERO:    len = '0;
      SZC_QUARTER: len = FULL_LEN >> 2;
      SZC_HALF:    len = FULL_LEN >> 1;
      default:     len = FULL_LEN;
    endcase
  end
endmodule

// File: rtl/cblk_prefix_sum.sv
module cblk_prefix_sum #(
  parameter int BLOCKS    = 64,
  parameter int SUBPAGES  = 2,
  parameter int BLK_BYTES = 64,
  parameter int LEN_W     = $clog2(BLK_BYTES + 1),
  parameter int IDX_W     = $clog2(BLOCKS),
  parameter int PS_W      = $clog2((BLOCKS / SUBPAGES) * BLK_BYTES + 1)
) (
  input  logic [2*BLOCKS-1:0] size_vec,
  input  logic [IDX_W-1:0]    idx,
  output logic [PS_W-1:0]     prefix,
  output logic [LEN_W-1:0]    own_len,
  output logic                own_zero
);
  localparam int SUB_BLKS = BLOCKS / SUBPAGES;

  logic [LEN_W-1:0] blk_len [BLOCKS];

  for (genvar j = 0; j < BLOCKS; j++) begin : g_dec
    cblk_size_decode #(.BLK_BYTES(BLK_BYTES), .LEN_W(LEN_W)) i_dec (
      .code (size_vec[2*j +: 2]),
      .len  (blk_len[j])
    );
  end

  always_comb begin
    int tgt;
    int tgt_sub;
    prefix  = '0;
    tgt     = int'(idx);
    tgt_sub = tgt / SUB_BLKS;
    for (int j = 0; j < BLOCKS; j++) begin
      if ((j / SUB_BLKS) == tgt_sub && j < tgt)
        prefix = prefix + PS_W'(blk_len[j]);
    end
  end

  assign own_len  = blk_len[idx];
  assign own_zero = (size_vec[2*idx +: 2] == 2'b00);
endmodule

// File: rtl/cblk_rsp_stage.sv
module cblk_rsp_stage #(
  parameter int OFF_W     = 13,
  parameter int LEN_W     = 7,
  parameter int BLK_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OFF_W-1:0] in_offset,
  input  logic [LEN_W-1:0] in_len,
  input  logic             in_zero,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OFF_W-1:0] out_offset,
  output logic [LEN_W-1:0] out_len,
  output logic             out_zero
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_offset <= '0;
      out_len    <= '0;
      out_zero   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_offset <= in_offset;
        out_len    <= in_len;
        out_zero   <= in_zero;
      end
    end
  end

  a_r6_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_offset)
                                   && $stable(out_len) && $stable(out_zero)));

  a_r7_no_accept_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r5_zero_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (out_len == '0));

  a_r1_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len <= LEN_W'(BLK_BYTES)));
endmodule

// File: rtl/cblk_addr_calc.sv
module cblk_addr_calc #(
  parameter int ADDR_W    = 32,
  parameter int BLOCKS    = 64,
  parameter int SUBPAGES  = 2,
  parameter int BLK_BYTES = 64,
  parameter int OFF_W     = $clog2(BLOCKS * BLK_BYTES) + 1,
  parameter int LEN_W     = $clog2(BLK_BYTES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [2*BLOCKS-1:0]        req_size_vec,
  input  logic [SUBPAGES*OFF_W-1:0]  req_sub_base,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [OFF_W-1:0]           rsp_offset,
  output logic [LEN_W-1:0]           rsp_len,
  output logic                       rsp_zero
);
  localparam int IDX_W    = $clog2(BLOCKS);
  localparam int BOFF_W   = $clog2(BLK_BYTES);
  localparam int SUB_BLKS = BLOCKS / SUBPAGES;
  localparam int SUB_W    = (SUBPAGES > 1) ? $clog2(SUBPAGES) : 1;
  localparam int PS_W     = $clog2(SUB_BLKS * BLK_BYTES + 1);

  logic [IDX_W-1:0] blk_idx;
  logic [SUB_W-1:0] sub_sel;
  logic [OFF_W-1:0] sub_base;
  logic [PS_W-1:0]  prefix;
  logic [LEN_W-1:0] own_len;
  logic             own_zero;
  logic [OFF_W-1:0] calc_offset;
  logic             unused_addr_bits;

  assign blk_idx          = req_addr[BOFF_W +: IDX_W];
  assign unused_addr_bits = ^{req_addr[BOFF_W-1:0], req_addr[ADDR_W-1:BOFF_W+IDX_W]};
  assign sub_sel          = SUB_W'(int'(blk_idx) / SUB_BLKS);
  assign sub_base         = req_sub_base[int'(sub_sel)*OFF_W +: OFF_W];

  cblk_prefix_sum #(
    .BLOCKS(BLOCKS), .SUBPAGES(SUBPAGES), .BLK_BYTES(BLK_BYTES),
    .LEN_W(LEN_W), .IDX_W(IDX_W), .PS_W(PS_W)
  ) i_psum (
    .size_vec (req_size_vec),
    .idx      (blk_idx),
    .prefix   (prefix),
    .own_len  (own_len),
    .own_zero (own_zero)
  );

  assign calc_offset = sub_base + OFF_W'(prefix);

  cblk_rsp_stage #(.OFF_W(OFF_W), .LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES)) i_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (req_valid),
    .in_ready   (req_ready),
    .in_offset  (calc_offset),
    .in_len     (own_len),
    .in_zero    (own_zero),
    .out_valid  (rsp_valid),
    .out_ready  (rsp_ready),
    .out_offset (rsp_offset),
    .out_len    (rsp_len),
    .out_zero   (rsp_zero)
  );

  a_r4_first_block_gets_base: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (int'(blk_idx) % SUB_BLKS == 0))
      |=> (rsp_offset == $past(sub_base)));

  a_r3_offset_not_below_base: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_offset >= $past(sub_base)));

  a_r8_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);
endmodule

// File: tb/test_cblk_addr_calc.sv
module test_cblk_addr_calc;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic [127:0] req_size_vec = '0;
  logic [25:0]  req_sub_base = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [12:0]  rsp_offset;
  logic [6:0]   rsp_len;
  logic         rsp_zero;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cblk_addr_calc i_cblk_addr_calc (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_size_vec,
    .req_sub_base, .rsp_valid, .rsp_ready, .rsp_offset, .rsp_len, .rsp_zero
  );

  function automatic int dec_len(logic [1:0] c);
    case (c)
      2'b00: return 0;
      2'b01: return 16;
      2'b10: return 32;
      default: return 64;
    endcase
  endfunction

  function automatic int exp_off(logic [31:0] a, logic [127:0] v, logic [25:0] b);
    int idx = int'(a[11:6]);
    int s = idx / 32;
    int acc = int'(b[s*13 +: 13]);
    for (int j = s * 32; j < idx; j++) acc += dec_len(v[2*j +: 2]);
    return acc % 8192;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, response visible at the next negedge
  task automatic issue(logic [31:0] a, logic [127:0] v, logic [25:0] b, string req);
    int idx = int'(a[11:6]);
    @(negedge clk);
    req_addr = a; req_size_vec = v; req_sub_base = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, int'(rsp_valid), 1);
    chk({req, " offset"}, int'(rsp_offset), exp_off(a, v, b));
    chk({req, " len"}, int'(rsp_len), dec_len(v[2*idx +: 2]));
    chk({req, " zero"}, int'(rsp_zero), int'(v[2*idx +: 2] == 2'b00));
  endtask

  task automatic t_reset();
    chk("R8 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R8 req_ready after reset", int'(req_ready), 1);
  endtask

  task automatic t_uniform();
    // R1 R3: every code value over a whole page
    for (int c = 0; c < 4; c++) begin
      logic [127:0] v = {64{2'(c)}};
      issue({20'h0, 6'd10, 6'd0}, v, 26'd0, "R1 R3 uniform blk10");
      issue({20'h0, 6'd40, 6'd0}, v, {13'd100, 13'd0}, "R3 uniform blk40");
    end
  endtask

  task automatic t_boundaries();
    logic [127:0] v = '0;
    logic [25:0]  b = {13'd2100, 13'd7};
    for (int j = 0; j < 64; j++) v[2*j +: 2] = 2'((j * 3 + 1) % 4);
    issue({20'h0, 6'd0,  6'd0}, v, b, "R4 block 0");
    issue({20'h0, 6'd32, 6'd0}, v, b, "R4 block 32");
    issue({20'h0, 6'd31, 6'd0}, v, b, "R3 block 31");
    issue({20'h0, 6'd63, 6'd0}, v, b, "R3 block 63");
    chk("R4 block 32 equals base", exp_off({20'h0, 6'd32, 6'd0}, v, b), 2100);
  endtask

  task automatic t_addr_noise();
    // R2 R9: noise outside bits [11:6]
    logic [127:0] v = '0;
    v[2*5 +: 2] = 2'b11; v[2*2 +: 2] = 2'b10; v[2*6 +: 2] = 2'b01;
    issue({20'hABCDE, 6'd6, 6'h3F}, v, {13'd0, 13'd50}, "R2 R9 addr noise");
    chk("R2 R9 offset value", int'(rsp_offset), 50 + 32 + 64);
    chk("R1 len value", int'(rsp_len), 16);
  endtask

  task automatic t_zero_block();
    logic [127:0] v = {64{2'b11}};
    v[2*20 +: 2] = 2'b00;
    issue({20'h0, 6'd20, 6'd0}, v, 26'd0, "R5 zero block");
    chk("R5 zero flag", int'(rsp_zero), 1);
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++) begin
      logic [127:0] v = {$urandom, $urandom, $urandom, $urandom};
      logic [25:0] b = {13'($urandom % 2048), 13'($urandom % 2048)};
      logic [31:0] a = $urandom;
      issue(a, v, b, "R3 random");
    end
  endtask

  task automatic t_stall();
    logic [127:0] v = {64{2'b01}};
    @(negedge clk);
    rsp_ready = 1'b0;
    req_addr = {20'h0, 6'd3, 6'd0}; req_size_vec = v; req_sub_base = 26'd0;
    req_valid = 1'b1;
    @(negedge clk);
    chk("R6 first valid", int'(rsp_valid), 1);
    chk("R6 first offset", int'(rsp_offset), 48);
    req_addr = {20'h0, 6'd9, 6'd0};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 ready low", int'(req_ready), 0);
      chk("R7 offset held", int'(rsp_offset), 48);
      chk("R7 valid held", int'(rsp_valid), 1);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 second after release", int'(rsp_offset), 144);
    @(negedge clk);
    chk("R6 drains", int'(rsp_valid), 0);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_uniform();
    t_boundaries();
    t_addr_noise();
    t_zero_block();
    t_random();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule